// File: doc/BRIEF.md
# Periodic Interval Timer with Square-Wave Output

This block is a general-purpose interval timer with three 32-bit registers on a simple synchronous read/write bus. A fixed prescaler divides the system clock by four, and each prescaler tick advances a counter. After a programmed number of ticks the counter returns to zero and the timer raises a period event. Each period event produces a single-cycle interrupt pulse. The timer output pin then either toggles, giving a square wave of system clock / (8 × period), or goes high for one tick.

Software stops the timer, loads a period, and starts it with a combined run-and-clear write. Interrupts then arrive at a steady rate, for example to pace a sampling routine. The period can be changed while the timer runs, and the change waits for the current interval to end, so no interval is cut short. The counter can be read at any time and overwritten directly.

Top module: `periodic_timer`

## Requirements
- R1: After synchronous reset, all three registers read 0 and both `irq` and `tout` are low.
- R2: Word addresses: 0x0 is control, 0x4 is period, 0x8 is counter. Any other address, including unaligned ones, reads 0 and ignores writes. Read data is registered and appears one cycle after the address. Control fields: bit 0 is output enable, bit 6 is run, bit 8 is mode (1 = toggle, 0 = pulse).
- R3: While run is 1, the counter advances once every four system clocks. After a run-and-clear write, the counter holds floor(N/4) after N further clocks, until the first wrap.
- R4: With active period P, a period event occurs every max(P,1) ticks, that is every 4·max(P,1) clocks, and the counter returns to 0. The first event comes 4·max(P,1) clocks after a run-and-clear write.
- R5: Each period event makes `irq` high for exactly one clock.
- R6: In toggle mode, `tout` inverts once per period event, so it changes level every 4·max(P,1) clocks.
- R7: In pulse mode, `tout` is high for 4 clocks after each period event and low for the rest of the interval.
- R8: With output enable at 0, `tout` stays low while events still occur.
- R9: With run at 0, the counter and the prescaler keep their values and no events occur. Resuming continues from the held prescaler phase.
- R10: Writing 1 to control bit 7 zeroes the counter, the prescaler and the output state in that write. The bit always reads back 0.
- R11: A counter write takes effect at once. If the written value is at or beyond the active period minus one, the next tick is a period event.
- R12: A period write while running takes effect at the next period event. While stopped, or with a clear, it takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data for the address of the previous cycle |
| irq | output | 1 | One-cycle pulse per period event |
| tout | output | 1 | Timer output pin (square wave or pulse) |

## Verification
The hardest points to reach from the ports are the prescaler phase and the deferred period switch. Neither is visible on the bus. The stimulus fixes the phase with a run-and-clear write and stops the timer after a known number of clocks. It then resumes and reads the counter in the one cycle where a held phase and a reset phase give different values. For the deferred period, the bench writes a new period just after an interrupt. It checks that the next interval still has the old length and only the one after it has the new length.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int CTL_OE   = 0;
  localparam int CTL_RUN  = 6;
  localparam int CTL_CLR  = 7;
  localparam int CTL_MODE = 8;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_PRD  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic mode;
    logic run;
    logic oe;
  } ctl_t;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  cnt_val,
  output ctl_t          ctl,
  output logic [W-1:0]  prd_shadow,
  output logic          clr,
  output logic          cnt_ld,
  output logic [W-1:0]  cnt_ld_val,
  output logic [W-1:0]  bus_rdata
);
  reg_sel_e sel;
  logic     in_range;

  // Word registers at 0x0/0x4/0x8; upper and low byte-lane bits must be zero.
  always_comb begin
    in_range = ((bus_addr >> 4) == '0) && (bus_addr[1:0] == 2'b00);
    sel      = in_range ? reg_sel_e'(bus_addr[3:2]) : SEL_NONE;
  end

  assign clr        = bus_wr && (sel == SEL_CTL) && bus_wdata[CTL_CLR];
  assign cnt_ld     = bus_wr && (sel == SEL_CNT);
  assign cnt_ld_val = bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl        <= '0;
      prd_shadow <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_CTL) begin
        ctl.oe   <= bus_wdata[CTL_OE];
        ctl.run  <= bus_wdata[CTL_RUN];
        ctl.mode <= bus_wdata[CTL_MODE];
      end
      if (sel == SEL_PRD) prd_shadow <= bus_wdata;
    end
  end

  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTL: begin
        rd_mux[CTL_OE]   = ctl.oe;
        rd_mux[CTL_RUN]  = ctl.run;
        rd_mux[CTL_MODE] = ctl.mode;
      end
      SEL_PRD: rd_mux = prd_shadow;
      SEL_CNT: rd_mux = cnt_val;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R2: period register follows an accepted write on the next cycle
  assert_prd_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_PRD) |=> (prd_shadow == $past(bus_wdata)));
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = run && !clr;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre;

      always_ff @(posedge clk) begin
        if (rst || clr)  pre <= '0;
        else if (run)    pre <= (pre == LAST) ? '0 : pre + 1'b1;
      end

      assign tick = run && !clr && (pre == LAST);

      // R9: phase frozen while stopped
      assert_pre_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(pre));
      // R3: ticks never on consecutive clocks
      assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         clr,
  input  logic         cnt_ld,
  input  logic [W-1:0] cnt_ld_val,
  input  logic [W-1:0] prd_shadow,
  output logic [W-1:0] cnt,
  output logic         irq,
  output logic         tog,
  output logic         pls
);
  localparam int W1 = W + 1;

  logic [W-1:0]  prd_act;
  logic [W1-1:0] cnt_next;
  logic          reached;
  logic          evt;

  always_comb begin
    cnt_next = {1'b0, cnt} + W1'(1);
    reached  = cnt_next >= {1'b0, prd_act};
    evt      = tick && reached && !clr && !cnt_ld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (cnt_ld) begin
      cnt <= cnt_ld_val;
    end else if (tick) begin
      cnt <= reached ? '0 : cnt_next[W-1:0];
    end
  end

  // Active period: follows the shadow while stopped or on clear, else at events.
  always_ff @(posedge clk) begin
    if (rst)                   prd_act <= '0;
    else if (!run || clr || evt) prd_act <= prd_shadow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      tog <= 1'b0;
      pls <= 1'b0;
    end else begin
      irq <= evt;
      if (clr) begin
        tog <= 1'b0;
        pls <= 1'b0;
      end else begin
        if (evt)       tog <= !tog;
        if (evt)       pls <= 1'b1;
        else if (tick) pls <= 1'b0;
      end
    end
  end

  // R9: counter frozen when stopped and not written
  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr && !cnt_ld) |=> $stable(cnt));
  // R4: interrupt coincides with a counter that has just wrapped
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnt == '0));
  // R6: toggle state moves only together with an interrupt
  assert_tog_evt_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(tog) && !$past(clr)) |-> irq);
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
  import ptmr_pkg::*;
#(
  parameter int W   = 32,
  parameter int AW  = 4,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq,
  output logic          tout
);
  ctl_t         ctl;
  logic [W-1:0] prd_shadow;
  logic         clr;
  logic         cnt_ld;
  logic [W-1:0] cnt_ld_val;
  logic [W-1:0] cnt;
  logic         tick;
  logic         tog;
  logic         pls;

  ptmr_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_val(cnt), .ctl(ctl), .prd_shadow(prd_shadow),
    .clr(clr), .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val), .bus_rdata(bus_rdata)
  );

  ptmr_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .run(ctl.run), .clr(clr), .tick(tick)
  );

  ptmr_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .run(ctl.run), .tick(tick), .clr(clr),
    .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val), .prd_shadow(prd_shadow),
    .cnt(cnt), .irq(irq), .tog(tog), .pls(pls)
  );

  always_ff @(posedge clk) begin
    if (rst) tout <= 1'b0;
    else     tout <= ctl.oe && (ctl.mode ? tog : pls);
  end

  // R8: disabled output stays low
  assert_oe_low_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl.oe |=> !tout);
  // R5: interrupt is a single-cycle pulse
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: tb/periodic_timer_tb.sv
module periodic_timer_tb;
  localparam int CLK_NS = 10;
  localparam logic [3:0] A_CTL = 4'h0, A_PRD = 4'h4, A_CNT = 4'h8;
  localparam logic [31:0] B_OE = 32'h1, B_RUN = 32'h40, B_CLR = 32'h80, B_MODE = 32'h100;
  localparam int NV = 7;
  localparam int VEC_P[NV]   = '{1, 2, 3, 5, 7, 0, 16};
  localparam int VEC_GAP[NV] = '{4, 8, 12, 20, 28, 4, 64};

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        tout;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  periodic_timer #(.W(32), .AW(4), .DIV(4)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tout(tout)
  );

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_irq(output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin t = cyc; break; end
    end
    if (t < 0) chk("R5 irq timeout", 0, 1);
  endtask

  task automatic wait_tout(input logic lvl, output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (tout == lvl) begin t = cyc; break; end
    end
    if (t < 0) chk("R6 tout timeout", 0, 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int t0, t1, t2, t3, cw, hits;
    bit tout_seen;
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 tout", tout, 0);
    rd(A_CTL, d); chk("R1 ctl", d, 0);
    rd(A_PRD, d); chk("R1 prd", d, 0);
    rd(A_CNT, d); chk("R1 cnt", d, 0);

    // Vector table: R4 interval, R6 toggle interval, R10 clear start point
    for (int v = 0; v < NV; v++) begin
      wr(A_CTL, 32'h0);
      wr(A_PRD, 32'(VEC_P[v]));
      wr(A_CTL, B_RUN | B_CLR | B_MODE | B_OE);
      t0 = cyc;
      wait_irq(t1);
      chk($sformatf("R4/R10 first event P=%0d", VEC_P[v]), t1 - t0, VEC_GAP[v]);
      wait_irq(t2);
      chk($sformatf("R4 interval P=%0d", VEC_P[v]), t2 - t1, VEC_GAP[v]);
      wait_tout(!tout, t1);
      wait_tout(!tout, t2);
      chk($sformatf("R6 toggle P=%0d", VEC_P[v]), t2 - t1, VEC_GAP[v]);
    end

    // R7 pulse mode, P=3
    wr(A_CTL, 32'h0);
    wr(A_PRD, 32'd3);
    wr(A_CTL, B_RUN | B_CLR | B_OE);
    wait_tout(1'b1, t1);
    wait_tout(1'b0, t2);
    wait_tout(1'b1, t3);
    chk("R7 pulse high", t2 - t1, 4);
    chk("R7 pulse low", t3 - t2, 8);

    // R8 output disabled, R5 count of single pulses
    wr(A_CTL, B_RUN | B_CLR | B_MODE);
    hits = 0; tout_seen = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (irq) hits++;
      if (tout) tout_seen = 1'b1;
    end
    chk("R8 tout low", tout_seen, 0);
    chk("R5 irq count", hits, 4);
    // R10 clear bit reads back 0; R2 control fields
    rd(A_CTL, d); chk("R10/R2 ctl readback", d, B_RUN | B_MODE);

    // R12 deferred period switch
    wr(A_CTL, 32'h0);
    wr(A_PRD, 32'd5);
    wr(A_CTL, B_RUN | B_CLR | B_MODE | B_OE);
    wait_irq(t1);
    wr(A_PRD, 32'd9);
    wait_irq(t2);
    wait_irq(t3);
    chk("R12 old interval kept", t2 - t1, 20);
    chk("R12 new interval", t3 - t2, 36);
    rd(A_PRD, d); chk("R2 prd readback", d, 9);

    // R11 counter beyond period: event at the very next tick
    wait_irq(t1);
    wr(A_CNT, 32'd200);
    cw = cyc;
    wait_irq(t2);
    chk("R11 early wrap", t2 - cw, 2);

    // R11 immediate load while stopped
    wr(A_CTL, B_MODE);
    wr(A_CNT, 32'd123);
    rd(A_CNT, d); chk("R11 load", d, 123);

    // R3 tick rate: 42 clocks after run-and-clear gives 10
    wr(A_PRD, 32'd1000);
    wr(A_CTL, B_RUN | B_CLR);
    repeat (40) @(negedge clk);
    wr(A_CTL, 32'h0);
    rd(A_CNT, d); chk("R3 count", d, 10);

    // R9 hold while stopped
    hits = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq) hits++;
    end
    chk("R9 no irq", hits, 0);
    rd(A_CNT, d); chk("R9 cnt held", d, 10);
    // R9 held prescaler phase: tick two clocks after resume
    wr(A_CTL, B_RUN);
    @(negedge clk);
    rd(A_CNT, d); chk("R9 phase kept", d, 11);

    // R2 unmapped and unaligned addresses
    rd(4'hC, d); chk("R2 unmapped", d, 0);
    rd(4'h6, d); chk("R2 unaligned", d, 0);
    wr(4'h5, 32'd77);
    rd(A_PRD, d); chk("R2 unaligned write ignored", d, 1000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule